// File: doc/BRIEF.md
# Raw IR Edge Interval Capture

This block measures how long a demodulated infrared receiver line stays at each level so that software can decode the remote-control protocol itself. The line is synchronized into the clock domain. A prescaler turns the system clock into ticks of a programmable length, and a saturating counter counts the ticks elapsed since the most recent transition of the line.

When a selected trigger occurs, the block captures two values and pulses an interrupt for one cycle. The trigger is a rising edge, a falling edge, either edge, or an external decoder event. The captured values are the elapsed tick count and a flag that tells whether the interval that just ended was a mark (carrier present, line low) or a space (line high). Software reads both values when it services the interrupt. In the usual raw setup the base time is 9, which gives 10 us ticks, and the block triggers on both edges.

Capture runs only while the enable input is high. A clear input zeroes the captured fields and restarts the timing. Software raises clear before it enables the block.

Top module: `ir_edge_timer`

## Requirements
- R1: After reset, cap_interval is 0, cap_mark is 0 and irq is 0.
- R2: One tick lasts (cfg_base_time+1)*US_CYCLES clock cycles. Let N be the number of clocks between two detected transitions. When the second transition triggers, cap_interval = floor((N-1)/tick length).
- R3: The interval counter stops at 8191, the 13-bit maximum, and does not wrap. A longer interval reads as 8191.
- R4: cfg_edge_sel picks the trigger: 0 = the dec_event input, 1 = both edges, 2 = falling edges only, 3 = rising edges only. A line edge that the setting does not select gives no irq and leaves the captured fields unchanged.
- R5: cap_mark is 1 when the interval being captured had the line low (mark), and 0 when it had the line high (space).
- R6: The interval counter restarts from zero on every transition of the line, including transitions that do not trigger a capture.
- R7: While cfg_enable is 0, no irq is raised, the captured fields hold their values, and the interval counter is held at zero.
- R8: While cfg_clear is high, the block does not run, even if cfg_enable is high. From the cycle after cfg_clear is first seen, cap_interval and cap_mark read 0 and irq is 0.
- R9: irq is high for exactly one cycle per trigger, in the same cycle as the new captured values. The captured values then hold until the next trigger.
- R10: ir_in passes through a two-flop synchronizer. irq for an edge appears three clocks after the ir_in change is set up ahead of a clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated IR line; low = mark, high = space (idle) |
| dec_event | input | 1 | One-cycle event from a decoder; triggers when cfg_edge_sel is 0 |
| cfg_enable | input | 1 | Run enable for capture |
| cfg_clear | input | 1 | Clears captured fields and timing state |
| cfg_base_time | input | 12 | Tick length minus one, in microseconds |
| cfg_edge_sel | input | 2 | Trigger source select |
| cap_interval | output | 13 | Captured elapsed ticks |
| cap_mark | output | 1 | 1 if the captured interval was a mark |
| irq | output | 1 | One-cycle capture interrupt |

## Verification
The assertions assume that ir_in is held idle high through reset. They also assume that cfg_base_time and cfg_edge_sel change only while the block is disabled or between edges. Under these conditions a capture always belongs to exactly one trigger cycle. The stimulus gives every line segment at least five clocks, so each edge is fully registered before the next change. It changes the base time only inside a disable, clear and enable sequence. Segment lengths and trigger selects are drawn at random from a fixed seed. Directed sequences add full-scale saturation, the decoder-event trigger, disable, and clear with enable held high.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam int IV_W = 13;

  typedef enum logic [1:0] {
    SRC_DECODER = 2'd0,
    SRC_BOTH    = 2'd1,
    SRC_FALL    = 2'd2,
    SRC_RISE    = 2'd3
  } trig_src_e;

  // Decides whether this cycle's events match the selected trigger source.
  function automatic logic trig_hit(trig_src_e src, logic rise, logic fall, logic dec);
    case (src)
      SRC_DECODER: return dec;
      SRC_BOTH:    return rise | fall;
      SRC_FALL:    return fall;
      default:     return rise;
    endcase
  endfunction

  // Next value of the interval counter: restart wins, otherwise saturate.
  function automatic logic [IV_W-1:0] iv_next(logic [IV_W-1:0] cur, logic restart,
                                              logic tick);
    if (restart) return '0;
    if (tick && (cur != {IV_W{1'b1}})) return cur + 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/irt_sync.sv
module irt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prv,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] shreg;

  // Reset to the idle level (high) so no edge is seen on release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      prv   <= 1'b1;
    end else begin
      shreg <= {shreg[STAGES-2:0], din};
      prv   <= shreg[STAGES-1];
    end
  end

  assign lvl  = shreg[STAGES-1];
  assign rise = lvl & ~prv;
  assign fall = ~lvl & prv;
endmodule

// File: rtl/irt_tick_gen.sv
module irt_tick_gen #(
  parameter int US_CYCLES = 24,
  parameter int BASE_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [BASE_W-1:0] base,
  output logic              tick
);
  localparam int US_W = (US_CYCLES > 1) ? $clog2(US_CYCLES) : 1;
  localparam logic [US_W-1:0] US_LAST = US_W'(US_CYCLES - 1);

  logic [US_W-1:0]   us_cnt;
  logic [BASE_W-1:0] base_cnt;
  logic              us_stb;

  assign us_stb = (us_cnt == US_LAST);
  assign tick   = us_stb && (base_cnt >= base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_cnt   <= '0;
      base_cnt <= '0;
    end else if (restart) begin
      us_cnt   <= '0;
      base_cnt <= '0;
    end else if (us_stb) begin
      us_cnt   <= '0;
      base_cnt <= tick ? '0 : base_cnt + 1'b1;
    end else begin
      us_cnt   <= us_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/irt_interval_cnt.sv
module irt_interval_cnt
  import irt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic            tick,
  output logic [IV_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (!run) count <= '0;
    else           count <= iv_next(count, restart, tick);
  end
endmodule

// File: rtl/ir_edge_timer.sv
module ir_edge_timer
  import irt_pkg::*;
#(
  parameter int US_CYCLES   = 24,
  parameter int BASE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              dec_event,
  input  logic              cfg_enable,
  input  logic              cfg_clear,
  input  logic [BASE_W-1:0] cfg_base_time,
  input  logic [1:0]        cfg_edge_sel,
  output logic [IV_W-1:0]   cap_interval,
  output logic              cap_mark,
  output logic              irq
);
  // Named internal events, also observed by the checker.
  logic            line_lvl, line_prv;
  logic            rise_evt, fall_evt, edge_any;
  logic            run, tick, trig;
  logic [IV_W-1:0] iv_cnt;

  irt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (ir_in),
    .lvl (line_lvl), .prv (line_prv), .rise (rise_evt), .fall (fall_evt)
  );

  assign run      = cfg_enable & ~cfg_clear;
  assign edge_any = rise_evt | fall_evt;

  irt_tick_gen #(.US_CYCLES(US_CYCLES), .BASE_W(BASE_W)) u_tick (
    .clk (clk), .rst_n (rst_n), .restart (edge_any | ~run),
    .base (cfg_base_time), .tick (tick)
  );

  irt_interval_cnt u_iv (
    .clk (clk), .rst_n (rst_n), .run (run), .restart (edge_any),
    .tick (tick), .count (iv_cnt)
  );

  assign trig = run & trig_hit(trig_src_e'(cfg_edge_sel), rise_evt, fall_evt, dec_event);

  // The previous line level is the level of the segment that is ending or ongoing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_interval <= '0;
      cap_mark     <= 1'b0;
      irq          <= 1'b0;
    end else if (cfg_clear) begin
      cap_interval <= '0;
      cap_mark     <= 1'b0;
      irq          <= 1'b0;
    end else begin
      irq <= trig;
      if (trig) begin
        cap_interval <= iv_cnt;
        cap_mark     <= ~line_prv;
      end
    end
  end

  logic unused_lvl;
  assign unused_lvl = line_lvl;
endmodule

// File: rtl/irt_checker.sv
module irt_checker
  import irt_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_clear,
  input logic [1:0]      cfg_edge_sel,
  input logic            run,
  input logic            edge_any,
  input logic            rise_evt,
  input logic            fall_evt,
  input logic [IV_W-1:0] iv_cnt,
  input logic            irq,
  input logic [IV_W-1:0] cap_interval,
  input logic            cap_mark
);
  assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !edge_any && iv_cnt == {IV_W{1'b1}}) |=> (iv_cnt == {IV_W{1'b1}}));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && edge_any) |=> (iv_cnt == '0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (iv_cnt == '0));

  assert_irq_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_clear) |-> (cap_interval == '0 && !cap_mark && !irq));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !$past(cfg_clear)) |-> ($stable(cap_interval) && $stable(cap_mark)));

  assert_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(cfg_edge_sel) == SRC_FALL) |-> $past(fall_evt));

  assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(cfg_edge_sel) == SRC_RISE) |-> $past(rise_evt));

  assert_edge_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
endmodule

bind ir_edge_timer irt_checker u_irt_checker (
  .clk (clk), .rst_n (rst_n), .cfg_clear (cfg_clear), .cfg_edge_sel (cfg_edge_sel),
  .run (run), .edge_any (edge_any), .rise_evt (rise_evt), .fall_evt (fall_evt),
  .iv_cnt (iv_cnt), .irq (irq), .cap_interval (cap_interval), .cap_mark (cap_mark)
);

// File: tb/ir_edge_timer_bench.sv
module ir_edge_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int USC        = 2;
  localparam int FULL       = 8191;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b1;
  logic        dec_event = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_clear = 1'b0;
  logic [11:0] cfg_base_time = 12'd0;
  logic [1:0]  cfg_edge_sel = 2'd1;
  logic [12:0] cap_interval;
  logic        cap_mark;
  logic        irq;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  int last_len = 0;
  bit have_len = 0;
  int exp_cap = 0;
  bit exp_mark = 0;
  bit done = 0;

  ir_edge_timer #(.US_CYCLES(USC)) u_ir_edge_timer (
    .clk (clk), .rst_n (rst_n), .ir_in (ir_in), .dec_event (dec_event),
    .cfg_enable (cfg_enable), .cfg_clear (cfg_clear), .cfg_base_time (cfg_base_time),
    .cfg_edge_sel (cfg_edge_sel), .cap_interval (cap_interval), .cap_mark (cap_mark),
    .irq (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (irq) irq_cnt++;

  function automatic int tick_len();
    return (int'(cfg_base_time) + 1) * USC;
  endfunction

  function automatic int exp_iv(int n);
    int v = (n - 1) / tick_len();
    return (v > FULL) ? FULL : v;
  endfunction

  function automatic bit will_fire(bit was);
    if (!cfg_enable || cfg_clear) return 0;
    case (cfg_edge_sel)
      2'd1: return 1;
      2'd2: return was;
      2'd3: return !was;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Called at a negedge: toggles the line and holds the new level for n cycles.
  task automatic seg(int n);
    bit was = ir_in;
    bit fire = will_fire(was);
    int c0 = irq_cnt;
    ir_in = ~was;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R10 no early irq", int'(irq), 0);
    @(negedge clk);
    chk(irq == fire, "R4 trigger select / R10 latency", int'(irq), int'(fire));
    if (fire) begin
      exp_cap  = have_len ? exp_iv(last_len) : exp_cap;
      exp_mark = (was == 1'b0);
      if (have_len)
        chk(int'(cap_interval) == exp_cap, "R2 interval R6 restart R3", int'(cap_interval), exp_cap);
      chk(cap_mark == exp_mark, "R5 mark flag", int'(cap_mark), int'(exp_mark));
      if (!have_len) exp_cap = int'(cap_interval);
    end else begin
      chk(int'(cap_interval) == exp_cap, "R7 R4 capture unchanged", int'(cap_interval), exp_cap);
    end
    @(negedge clk);
    chk(irq == 1'b0, "R9 single-cycle irq", int'(irq), 0);
    repeat (n - 4) @(negedge clk);
    chk(irq_cnt - c0 == int'(fire), "R9 irq count", irq_cnt - c0, int'(fire));
    last_len = n;
    have_len = cfg_enable && !cfg_clear;
  endtask

  // Clears, then enables; the first interval is counted from the clear release.
  task automatic start_run(int base);
    cfg_enable = 1'b0;
    repeat (6) @(negedge clk);
    cfg_base_time = 12'(base);
    cfg_clear = 1'b1;
    @(negedge clk);
    chk(cap_interval == 0 && cap_mark == 0, "R8 clear zeroes fields", int'(cap_interval), 0);
    exp_cap = 0; exp_mark = 0;
    cfg_clear = 1'b0;
    cfg_enable = 1'b1;
    repeat (6) @(negedge clk);
    last_len = 9;
    have_len = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cap_interval == 0, "R1 reset interval", int'(cap_interval), 0);
    chk(cap_mark == 0, "R1 reset mark", int'(cap_mark), 0);
    chk(irq == 0, "R1 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed: both edges, 2-cycle tick, including the first interval after clear.
    cfg_edge_sel = 2'd1;
    start_run(0);
    seg(20); seg(21); seg(7); seg(5); seg(40);
    // Saturation: 20000 clocks at tick 2 exceeds full scale.
    seg(20000);
    seg(10);
    chk(int'(cap_interval) == FULL, "R3 saturated reading", int'(cap_interval), FULL);

    // Falling only / rising only: non-triggering edges still restart the count.
    cfg_edge_sel = 2'd2;
    seg(30); seg(17); seg(25); seg(12);
    cfg_edge_sel = 2'd3;
    seg(33); seg(9); seg(44); seg(6);

    // Decoder-event source: edges give nothing, dec_event captures the ongoing count.
    cfg_edge_sel = 2'd0;
    seg(15);
    seg(30);
    dec_event = 1'b1;
    @(negedge clk);
    dec_event = 1'b0;
    chk(irq == 1'b1, "R4 decoder event irq", int'(irq), 1);
    chk(int'(cap_interval) == (30 - 3) / tick_len(), "R4 decoder event interval",
        int'(cap_interval), (30 - 3) / tick_len());
    chk(cap_mark == (ir_in == 1'b0), "R5 decoder event mark", int'(cap_mark), int'(ir_in == 1'b0));
    exp_cap = int'(cap_interval); exp_mark = cap_mark;
    @(negedge clk);
    last_len = 32;

    // Disabled: edges give no irq and fields hold.
    cfg_edge_sel = 2'd1;
    cfg_enable = 1'b0;
    seg(12); seg(14); seg(9);

    // Clear while enable stays high.
    cfg_enable = 1'b1;
    seg(11);
    cfg_clear = 1'b1;
    @(negedge clk);
    chk(cap_interval == 0 && cap_mark == 0 && irq == 0, "R8 clear over enable",
        int'(cap_interval), 0);
    cfg_clear = 1'b0;
    exp_cap = 0; exp_mark = 0;
    have_len = 0;
    seg(8); seg(13);

    // Random rounds with varied base time and trigger select.
    void'($urandom(32'h1A2B3C4D));
    for (int r = 0; r < 6; r++) begin
      cfg_edge_sel = 2'($urandom_range(1, 3));
      start_run(int'($urandom_range(0, 3)));
      for (int k = 0; k < 25; k++) begin
        if ($urandom_range(0, 4) == 0) cfg_edge_sel = 2'($urandom_range(0, 3));
        seg(int'($urandom_range(5, 200)));
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule